// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address sequence for one SDRAM read or write burst. A single-cycle load strobe captures a starting column, a burst length code and a wrap order. From the next clock on, the block presents one column address per cycle with a valid flag. The final address of a burst is marked with a last flag.

The block supports linear (sequential) and interleaved wrap orders for bursts of 1, 2, 4 and 8 beats. It also has a full-page mode that walks the whole row and only ends when a stop request arrives. A controller issues a new load on any cycle, including the cycle of the final beat, so bursts can run back to back with a one-clock column-to-column spacing. A stop request ends a burst early.

Top module: `col_burst_seq`

## Requirements
- R1: After reset, and until the first load, `colValid` and `colLast` are low.
- R2: When `loadEn` is sampled high at a clock edge, `colValid` is high in the following cycle and `colOut` equals the loaded start column (beat 0).
- R3: `lenSel` encodes the burst length as 0→1, 1→2, 2→4, 3→8 and 7→full page. Codes 4, 5 and 6 act as length 1. A burst of length N keeps `colValid` high for exactly N cycles and then drops it.
- R4: With `interleave` low and length N, beat k outputs the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits are unchanged.
- R5: With `interleave` high and length N, beat k outputs the start column with its low log2(N) bits XORed with k.
- R6: In full-page mode, beat k outputs (start + k) mod 1024, wrapping from 1023 to 0. `interleave` has no effect. The burst never ends by itself and `colLast` stays low.
- R7: `colLast` is high only on the final beat of a burst of length 1, 2, 4 or 8. A length-1 burst raises `colValid` and `colLast` together for a single cycle.
- R8: A `stopReq` sampled high while a burst is active and no load is present ends the burst, so `colValid` is low in the next cycle. A `stopReq` while idle has no effect.
- R9: A load sampled during an active burst discards the old burst, including on its last beat or alongside a stop request. The new sequence's beat 0 appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Start a new burst using the fields below |
| loadCol | input | COL_W | Starting column address |
| lenSel | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved wrap order, 0 sequential |
| stopReq | input | 1 | Terminate the active burst |
| colOut | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A burst beat is presented this cycle |
| colLast | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
The bench sweeps every start column through both wrap orders and every fixed length. This catches a carry that leaks out of the wrap window into the upper bits, or an interleaved order that behaves like an add. Full-page runs cross the 1023-to-0 boundary and go past 1024 beats, which exposes a design that stops by itself, raises the last flag, or honours the interleave bit in that mode. The bench also issues a stop in the middle of a burst, a stop while idle, a load together with a stop, and a load on the last beat. A design that drops the restart, adds a bubble between back-to-back bursts, or lets stop override load shows a missing or stale address in those cycles.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

  // Strobes from the control FSM to the address datapath
  typedef struct packed {
    logic load;   // capture a new start column and clear the beat offset
    logic step;   // advance to the next beat
  } colStrobe_t;

  localparam int LEN_SEL_W = 3;
  localparam logic [LEN_SEL_W-1:0] LEN_FULL = 3'd7;

endpackage

// File: rtl/col_burst_ctrl.sv
module col_burst_ctrl
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [LEN_SEL_W-1:0] lenSel,
  input  logic                 stopReq,
  output colStrobe_t           strb,
  output logic [COL_W-1:0]     lenMask,
  output logic                 fullPage,
  output logic                 colValid,
  output logic                 colLast
);

  localparam logic [COL_W-1:0] MASK1 = '0;
  localparam logic [COL_W-1:0] MASK2 = COL_W'(1);
  localparam logic [COL_W-1:0] MASK4 = COL_W'(3);
  localparam logic [COL_W-1:0] MASK8 = COL_W'(7);
  localparam logic [COL_W-1:0] MASKF = '1;

  logic             activeQ;
  logic             fullQ;
  logic [COL_W-1:0] maskQ;
  logic [COL_W-1:0] remQ;
  logic [COL_W-1:0] newMask;
  logic             newFull;
  logic             burstDone;

  always_comb begin
    newFull = 1'b0;
    unique case (lenSel)
      3'd0:     newMask = MASK1;
      3'd1:     newMask = MASK2;
      3'd2:     newMask = MASK4;
      3'd3:     newMask = MASK8;
      LEN_FULL: begin newMask = MASKF; newFull = 1'b1; end
      default:  newMask = MASK1;
    endcase
  end

  assign burstDone = !fullQ && (remQ == '0);
  assign strb.load = loadEn;
  assign strb.step = activeQ && !loadEn && !stopReq && !burstDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
      maskQ   <= '0;
      remQ    <= '0;
    end else if (loadEn) begin
      activeQ <= 1'b1;
      fullQ   <= newFull;
      maskQ   <= newMask;
      remQ    <= newMask;
    end else if (activeQ) begin
      if (stopReq || burstDone) begin
        activeQ <= 1'b0;
      end else if (!fullQ) begin
        remQ <= remQ - COL_W'(1);
      end
    end
  end

  assign lenMask  = maskQ;
  assign fullPage = fullQ;
  assign colValid = activeQ;
  assign colLast  = activeQ && burstDone;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> !colLast);
  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> colValid);
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    colLast && !loadEn |=> !colValid);
  assert_full_no_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    fullPage |-> !colLast);
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    colValid && stopReq && !loadEn |=> !colValid);
  assert_stays_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !colValid && !loadEn |=> !colValid);

endmodule

// File: rtl/col_burst_addr.sv
module col_burst_addr
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strb,
  input  logic [COL_W-1:0] loadCol,
  input  logic             interleave,
  input  logic [COL_W-1:0] lenMask,
  input  logic             fullPage,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] offQ;
  logic             ilvQ;
  logic             useXor;
  logic [COL_W-1:0] lowPart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      offQ   <= '0;
      ilvQ   <= 1'b0;
    end else if (strb.load) begin
      startQ <= loadCol;
      offQ   <= '0;
      ilvQ   <= interleave;
    end else if (strb.step) begin
      offQ <= offQ + COL_W'(1);
    end
  end

  // Full page ignores the wrap order and walks the row linearly.
  assign useXor  = ilvQ && !fullPage;
  assign lowPart = useXor ? (startQ ^ offQ) : (startQ + offQ);
  assign colOut  = (startQ & ~lenMask) | (lowPart & lenMask);

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !useXor |=> ((colOut - $past(colOut)) & lenMask) == COL_W'(1));
  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((colOut ^ $past(colOut)) & ~lenMask) == '0);
  assert_no_load_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.step));

endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [COL_W-1:0]     loadCol,
  input  logic [LEN_SEL_W-1:0] lenSel,
  input  logic                 interleave,
  input  logic                 stopReq,
  output logic [COL_W-1:0]     colOut,
  output logic                 colValid,
  output logic                 colLast
);

  colStrobe_t       strb;
  logic [COL_W-1:0] lenMask;
  logic             fullPage;

  col_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .lenSel   (lenSel),
    .stopReq  (stopReq),
    .strb     (strb),
    .lenMask  (lenMask),
    .fullPage (fullPage),
    .colValid (colValid),
    .colLast  (colLast)
  );

  col_burst_addr #(.COL_W(COL_W)) u_addr (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadCol    (loadCol),
    .interleave (interleave),
    .lenMask    (lenMask),
    .fullPage   (fullPage),
    .colOut     (colOut)
  );

endmodule

// File: tb/col_burst_seq_test.sv
`timescale 1ns/1ps
module col_burst_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [9:0] loadCol = '0;
  logic [2:0] lenSel = '0;
  logic       interleave = 1'b0;
  logic       stopReq = 1'b0;
  logic [9:0] colOut;
  logic       colValid;
  logic       colLast;

  int vecs = 0;
  int bad  = 0;

  always #4 clk = ~clk;

  col_burst_seq #(.COL_W(10)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadCol(loadCol),
    .lenSel(lenSel), .interleave(interleave), .stopReq(stopReq),
    .colOut(colOut), .colValid(colValid), .colLast(colLast)
  );

  function automatic int lenOf(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int expCol(int s, int n, bit ilv, int k);
    int mask;
    if (n == 0) return (s + k) % 1024;
    mask = n - 1;
    return ((s & ~mask) | (ilv ? ((s ^ k) & mask) : ((s + k) & mask))) & 1023;
  endfunction

  task automatic chk(string req, bit v, bit l, int c);
    vecs++;
    if (colValid !== v || colLast !== l || (v && colOut !== 10'(c))) begin
      bad++;
      $display("FAIL %s: got valid=%0b last=%0b col=%0d, expected valid=%0b last=%0b col=%0d",
               req, colValid, colLast, colOut, v, l, c);
    end
  endtask

  task automatic drive(int s, int code, bit ilv);
    loadCol    = 10'(s);
    lenSel     = 3'(code);
    interleave = ilv;
    loadEn     = 1'b1;
  endtask

  // R2 R3 R4 R5 R7: one fixed-length burst, then an idle check
  task automatic runBurst(int s, int code, bit ilv, string req);
    int n;
    n = lenOf(code);
    drive(s, code, ilv);
    @(negedge clk);
    loadEn = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(req, 1'b1, k == n - 1, expCol(s, n, ilv, k));
      @(negedge clk);
    end
    chk(req, 1'b0, 1'b0, 0);
  endtask

  // R6 R8: full-page run stopped after a number of beats
  task automatic runFull(int s, bit ilv, int beats);
    drive(s, 7, ilv);
    @(negedge clk);
    loadEn = 1'b0;
    for (int k = 0; k < beats; k++) begin
      chk("R6", 1'b1, 1'b0, expCol(s, 0, ilv, k));
      if (k == beats - 1) stopReq = 1'b1;
      @(negedge clk);
    end
    stopReq = 1'b0;
    chk("R8", 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0, 0);

    // Exhaustive sweep of fixed lengths, both wrap orders (R4, R5, R7)
    for (int s = 0; s < 1024; s++) begin
      for (int ilv = 0; ilv < 2; ilv++) begin
        for (int code = 0; code < 4; code++) begin
          runBurst(s, code, ilv[0], ilv ? "R5" : (code == 0 ? "R7" : "R4"));
        end
      end
    end

    // Reserved codes act as length 1 (R3)
    for (int s = 0; s < 1024; s += 37) begin
      for (int code = 4; code < 7; code++) runBurst(s, code, s[0], "R3");
    end

    // Full page, short runs, both orders (R6)
    for (int s = 0; s < 1024; s += 7) begin
      runFull(s, 1'b0, 12);
      runFull(s, 1'b1, 12);
    end
    runFull(1023, 1'b1, 3);
    // Full page never ends by itself, crosses the wrap (R6)
    runFull(1020, 1'b0, 1030);

    // Stop in the middle of an 8-beat burst (R8)
    drive(100, 3, 1'b0);
    @(negedge clk);
    loadEn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R8", 1'b1, 1'b0, expCol(100, 8, 1'b0, k));
      if (k == 3) stopReq = 1'b1;
      @(negedge clk);
    end
    stopReq = 1'b0;
    chk("R8", 1'b0, 1'b0, 0);

    // Stop while idle has no effect (R8)
    stopReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8", 1'b0, 1'b0, 0);
    stopReq = 1'b0;
    runBurst(300, 2, 1'b0, "R8");

    // Load together with stop during a burst: load wins (R9)
    drive(200, 3, 1'b0);
    @(negedge clk);
    loadEn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R9", 1'b1, 1'b0, expCol(200, 8, 1'b0, k));
      if (k == 2) begin
        drive(517, 2, 1'b1);
        stopReq = 1'b1;
      end
      @(negedge clk);
    end
    loadEn  = 1'b0;
    stopReq = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R9", 1'b1, k == 3, expCol(517, 4, 1'b1, k));
      @(negedge clk);
    end
    chk("R9", 1'b0, 1'b0, 0);

    // Back-to-back: load on the last beat (R9)
    drive(33, 1, 1'b0);
    @(negedge clk);
    loadEn = 1'b0;
    for (int k = 0; k < 2; k++) begin
      chk("R9", 1'b1, k == 1, expCol(33, 2, 1'b0, k));
      if (k == 1) drive(900, 3, 1'b0);
      @(negedge clk);
    end
    loadEn = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R9", 1'b1, k == 7, expCol(900, 8, 1'b0, k));
      @(negedge clk);
    end
    chk("R9", 1'b0, 1'b0, 0);

    // Load during a full-page run restarts it (R9)
    drive(10, 7, 1'b0);
    @(negedge clk);
    chk("R9", 1'b1, 1'b0, 10);
    drive(6, 0, 1'b0);
    @(negedge clk);
    loadEn = 1'b0;
    chk("R9", 1'b1, 1'b1, 6);
    @(negedge clk);
    chk("R9", 1'b0, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule